// File: doc/BRIEF.md
# Two-Wire Serial Slave with 256-Byte Array

This block is a slave on a two-wire serial bus (SCL clock, SDA data) that gives an external master access to an array of 256 eight-bit locations. It filters both bus lines through a short synchronizer into a fast system clock. It detects Start and Stop conditions and collects each byte MSB first. After each byte it answers with an acknowledge bit in the ninth clock. SDA is never driven high: the block only asserts an open-drain pull-down enable.

A transfer opens with a seven-bit device address and a direction bit. The top four address bits are the fixed pattern 1010. The next three must equal the strap inputs, so eight copies can share one bus. In a write, the first byte after the address sets the internal location pointer and every later byte is stored there. In a read, bytes stream out from the pointer. The pointer steps by one after every byte in both directions and rolls over from FFh to 00h. A repeated Start after the pointer byte turns a write into a read from a chosen location. Two inputs block stores to the array: a write-protect level and a supply-good flag. The bus handshake stays unchanged while stores are blocked.

Top module: `i2c_bytemem`

## Requirements
- R1: While reset is asserted, and after its release until a transfer addresses the block, the pull-down enable `sda_oe` is low.
- R2: The block acknowledges the address byte only when its bits 7..4 equal 1010 and its bits 3..1 equal `strap[2:0]`. Bit 0 is the direction: 1 means read. On any other address it gives no acknowledge and ignores the bus until the next Start.
- R3: In a write, the block acknowledges the pointer byte and each data byte. Data bytes are stored at the pointer, and the pointer then advances by one.
- R4: While `wp` is high, data bytes are still acknowledged, but the array keeps its contents.
- R5: While `supply_ok` is low, data bytes are still acknowledged, but the array keeps its contents.
- R6: In a read, each byte is sent MSB first from the pointer, and the pointer advances after each byte, wrapping from FFh to 00h. A read with no preceding pointer byte starts where the last transfer left the pointer.
- R7: After the master answers a read byte with no acknowledge (SDA high), the block releases SDA and drives nothing until the next Start.
- R8: A Stop returns the block to idle. A Start, including one repeated without a Stop, begins a new address phase and keeps the pointer.
- R9: The block changes `sda_oe` only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least eight times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock as seen on the wire |
| sda_i | input | 1 | Bus data as seen on the wire |
| sda_oe | output | 1 | High to pull SDA low |
| strap | input | 3 | Low device-address bits chosen by board wiring |
| wp | input | 1 | High blocks all stores to the array |
| supply_ok | input | 1 | Low blocks all stores to the array |

## Verification
The master model runs several kinds of transfer:
- a multi-byte write followed by a random read through a repeated Start, which separates pointer loading from data storage;
- a mismatched strap value and a mismatched fixed prefix, which show whether both address fields are compared;
- writes under write-protect and under a low supply flag, each read back afterwards, which separate acknowledge behaviour from storage;
- a write and a read across FFh, plus a current-address read, which show wrap-around and pointer retention across transfers;
- a Stop in the middle of a write, which shows that the data written before the Stop is kept.

A scoreboard holds the expected read bytes in order, so any error in bit order or pointer stepping shows as a mismatch in sequence.

// File: rtl/i2c_bytemem.sv
module i2c_bytemem #(
  parameter logic [3:0] DEV_ID = 4'b1010,
  parameter int AW = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] strap,
  input  logic       wp,
  input  logic       supply_ok
);
  localparam int DEPTH = 1 << AW;
  localparam int BW = 8;
  localparam int CW = $clog2(BW + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_DEV, S_WADR, S_WDAT, S_ACK, S_RDAT, S_RACK
  } st_t;

  st_t st, after;
  logic [2:0] scl_q, sda_q;
  logic [BW-1:0] sh;
  logic [CW-1:0] cnt;
  logic [AW-1:0] ptr;
  logic mack;
  logic [BW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end

  wire scl_s    = scl_q[1];
  wire sda_s    = sda_q[1];
  wire scl_rise = scl_q[1] & ~scl_q[2];
  wire scl_fall = ~scl_q[1] & scl_q[2];
  wire scl_hi   = scl_q[1] & scl_q[2];
  wire start_c  = scl_hi & sda_q[2] & ~sda_q[1];
  wire stop_c   = scl_hi & ~sda_q[2] & sda_q[1];
  wire byte_in  = scl_fall && (cnt == CW'(BW));
  wire match    = (sh[7:4] == DEV_ID) && (sh[3:1] == strap);
  wire we       = byte_in && (st == S_WDAT) && !wp && supply_ok;
  wire [BW-1:0] rd_byte = mem[ptr];

  always_ff @(posedge clk)
    if (we) mem[ptr] <= sh;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st     <= S_IDLE;
      after  <= S_IDLE;
      sda_oe <= 1'b0;
      sh     <= '0;
      cnt    <= '0;
      ptr    <= '0;
      mack   <= 1'b0;
    end else if (start_c) begin
      st     <= S_DEV;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (stop_c) begin
      st     <= S_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (st)
        S_DEV, S_WADR, S_WDAT: begin
          if (scl_rise) begin
            sh  <= {sh[BW-2:0], sda_s};
            cnt <= cnt + 1'b1;
          end else if (byte_in) begin
            cnt <= '0;
            if (st == S_DEV) begin
              if (match) begin
                sda_oe <= 1'b1;
                st     <= S_ACK;
                after  <= sh[0] ? S_RDAT : S_WADR;
              end else begin
                st <= S_IDLE;
              end
            end else begin
              sda_oe <= 1'b1;
              st     <= S_ACK;
              after  <= S_WDAT;
              if (st == S_WADR) ptr <= sh[AW-1:0];
              else              ptr <= ptr + 1'b1;
            end
          end
        end
        S_ACK: begin
          if (scl_fall) begin
            st  <= after;
            cnt <= '0;
            if (after == S_RDAT) begin
              sh     <= rd_byte;
              sda_oe <= ~rd_byte[BW-1];
            end else begin
              sda_oe <= 1'b0;
            end
          end
        end
        S_RDAT: begin
          if (scl_rise) begin
            cnt <= cnt + 1'b1;
          end else if (scl_fall) begin
            if (cnt == CW'(BW)) begin
              sda_oe <= 1'b0;
              st     <= S_RACK;
              ptr    <= ptr + 1'b1;
            end else begin
              sh     <= {sh[BW-2:0], 1'b0};
              sda_oe <= ~sh[BW-2];
            end
          end
        end
        S_RACK: begin
          if (scl_rise) begin
            mack <= ~sda_s;
          end else if (scl_fall) begin
            if (mack) begin
              sh     <= rd_byte;
              sda_oe <= ~rd_byte[BW-1];
              cnt    <= '0;
              st     <= S_RDAT;
            end else begin
              st <= S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end

  logic unused;
  assign unused = scl_s;
endmodule

// File: rtl/i2c_bytemem_chk.sv
module i2c_bytemem_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_i,
  input logic          sda_oe,
  input logic [2:0]    st,
  input logic [AW-1:0] ptr
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !sda_oe);

  // R9
  scl_high_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i)) |-> $stable(sda_oe));

  // R7
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0) |-> !sda_oe);

  // R6
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ptr) == '1 && ptr != $past(ptr) && $past(st) != 3'd2) |-> ptr == '0);
endmodule

bind i2c_bytemem i2c_bytemem_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .st(st), .ptr(ptr)
);

// File: tb/i2c_bytemem_bench.sv
module i2c_bytemem_bench;
  logic clk = 0, rst_n = 0, scl = 1, sda_m = 1, wp = 0, supply_ok = 1;
  logic [2:0] strap = 3'b101;
  logic sda_oe;
  wire sda_bus = sda_m & ~sda_oe;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  i2c_bytemem u_i2c_bytemem (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .strap(strap), .wp(wp), .supply_ok(supply_ok)
  );

  localparam logic [7:0] DEVW = 8'b1010_101_0;
  localparam logic [7:0] DEVR = 8'b1010_101_1;

  logic [7:0] exp_q [$];
  string tag_q [$];
  logic [7:0] rx_byte;
  event rx_ev;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hw(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [7:0] b, input string tag);
    exp_q.push_back(b);
    tag_q.push_back(tag);
  endtask

  initial forever begin
    @(rx_ev);
    if (exp_q.size() == 0) chk(0, "scoreboard unexpected byte", rx_byte, 0);
    else begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(rx_byte == e, t, rx_byte, e);
    end
  end

  logic r9_bad = 0, scl_d = 1, oe_d = 0;
  always @(negedge clk) begin
    if (rst_n && scl && scl_d && sda_oe != oe_d) r9_bad = 1;
    scl_d = scl;
    oe_d = sda_oe;
  end

  task automatic start_c();
    hw(4); sda_m = 1; hw(6); scl = 1; hw(10); sda_m = 0; hw(10); scl = 0;
  endtask

  task automatic stop_c();
    hw(4); sda_m = 0; hw(6); scl = 1; hw(10); sda_m = 1; hw(10);
  endtask

  task automatic send(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      hw(4); sda_m = b[i]; hw(6); scl = 1; hw(10); scl = 0;
    end
    hw(4); sda_m = 1; hw(6); scl = 1; hw(5); ack = ~sda_bus; hw(5); scl = 0;
  endtask

  task automatic recv(input logic m_ack);
    logic [7:0] b;
    b = '0;
    hw(4); sda_m = 1;
    for (int i = 0; i < 8; i++) begin
      hw(6); scl = 1; hw(5); b = {b[6:0], sda_bus}; hw(5); scl = 0; hw(4);
    end
    rx_byte = b;
    -> rx_ev;
    sda_m = ~m_ack; hw(6); scl = 1; hw(10); scl = 0; hw(4); sda_m = 1;
  endtask

  task automatic wr(input logic [7:0] adr, input logic [7:0] d0, d1, d2,
                    input int n, input string tag);
    logic a;
    logic [7:0] d [3];
    d[0] = d0; d[1] = d1; d[2] = d2;
    start_c();
    send(DEVW, a); chk(a, {tag, " address ack"}, a, 1);
    send(adr, a);  chk(a, {tag, " pointer ack"}, a, 1);
    for (int k = 0; k < n; k++) begin
      send(d[k], a); chk(a, {tag, " data ack"}, a, 1);
    end
    stop_c();
  endtask

  task automatic rd_from(input logic [7:0] adr, input int n, input string tag);
    logic a;
    start_c();
    send(DEVW, a); chk(a, {tag, " address ack"}, a, 1);
    send(adr, a);  chk(a, {tag, " pointer ack"}, a, 1);
    start_c();
    send(DEVR, a); chk(a, "R8 repeated start read ack", a, 1);
    for (int k = 0; k < n; k++) recv(k != n - 1);
    hw(6);
    chk(!sda_oe, "R7 released after master nack", sda_oe, 0);
    stop_c();
  endtask

  initial begin
    automatic logic a;
    hw(5);
    chk(!sda_oe, "R1 in reset", sda_oe, 0);
    rst_n = 1;
    hw(10);
    chk(!sda_oe, "R1 after reset", sda_oe, 0);

    wr(8'h10, 8'hA5, 8'h3C, 8'h00, 2, "R3");
    push(8'hA5, "R6 read first byte");
    push(8'h3C, "R6 read second byte");
    rd_from(8'h10, 2, "R3");

    start_c();
    send(8'b1010_000_0, a); chk(!a, "R2 strap mismatch no ack", a, 0);
    send(8'h55, a);         chk(!a, "R2 byte ignored after mismatch", a, 0);
    stop_c();
    start_c();
    send(8'b1011_101_0, a); chk(!a, "R2 prefix mismatch no ack", a, 0);
    stop_c();

    wp = 1;
    wr(8'h10, 8'hFF, 8'h00, 8'h00, 1, "R4");
    wp = 0;
    push(8'hA5, "R4 protected location unchanged");
    rd_from(8'h10, 1, "R4");

    supply_ok = 0;
    wr(8'h11, 8'h00, 8'h00, 8'h00, 1, "R5");
    supply_ok = 1;
    push(8'h3C, "R5 low-supply location unchanged");
    rd_from(8'h11, 1, "R5");

    wr(8'hFF, 8'h11, 8'h22, 8'h5A, 3, "R6 wrap write");
    push(8'h11, "R6 byte at FF");
    push(8'h22, "R6 byte at 00 after wrap");
    rd_from(8'hFF, 2, "R6");
    push(8'h5A, "R6 current address read");
    start_c();
    send(DEVR, a); chk(a, "R6 current read address ack", a, 1);
    recv(0);
    stop_c();

    start_c();
    send(DEVW, a); send(8'h20, a); send(8'h77, a);
    chk(a, "R8 data ack before stop", a, 1);
    stop_c();
    push(8'h77, "R8 byte kept across stop");
    rd_from(8'h20, 1, "R8");

    hw(20);
    chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    chk(!r9_bad, "R9 sda_oe held while SCL high", r9_bad, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule